// File: doc/BRIEF.md
# FIFO Test-Read Register Port

This block holds a small first-in first-out store of 16-bit words. The transfer datapath fills it through a push port. A host register bus sits beside it. In normal operation the host cannot change the FIFO. When software sets the test-read enable bit in an 8-bit control register, the host can empty the store through a data register. Each read of that register may use the whole word or a single byte lane.

The byte lanes decide whether a read removes an entry. A read that includes the low lane removes the head entry. A read of the high lane alone only looks at the head. To recover a full word one byte at a time, software reads the high byte first and the low byte second. Reads while the store is empty set a sticky error flag. The block reports empty, full and an occupancy count.

Top module: `fifo_tread_port`

## Requirements
- R1: After reset (or a reset in the middle of a run), all eight control bits read 0, the occupancy is 0, empty is 1, full is 0, underflow is 0, and test reads are disabled.
- R2: A write to address 0 with lane 0 enabled stores bus_wdata[7:0] into the control register, and a read of address 0 returns it in bus_rdata[7:0]. Bit 6 is the test-read enable. Bit 7 (active negation), bit 5 (clock halt) and bits 4 to 0 are stored and read back only.
- R3: A push while not full stores one entry and raises the count by 1. Full is 1 at 8 entries. A push while full is ignored and leaves both the count and the contents unchanged.
- R4: With test read enabled, a read of address 1 with bus_be=2'b11 returns head bits 15:0 and removes the head entry.
- R5: With test read enabled, a read of address 1 with bus_be=2'b01 returns head bits 7:0 in bus_rdata[7:0], with zeros above, and removes the head entry.
- R6: With test read enabled, a read of address 1 with bus_be=2'b10 returns head bits 15:8 in bus_rdata[15:8], with zeros below, and does not remove an entry. A high-then-low pair therefore returns both halves of the same entry.
- R7: With test read disabled, reads of address 1 return 0 and leave the count and the contents unchanged.
- R8: With test read enabled, a read of address 1 with any lane while the store is empty returns 0, removes nothing, and sets underflow. Underflow also reads as bit 0 of address 2. It is cleared only by a write of 1 to that bit with lane 0 enabled. A write of 0 leaves it set.
- R9: A push and an entry-removing read in the same cycle, with the store neither empty nor full, leave the count unchanged and keep the entries in their order.
- R10: bus_rdata is registered. It carries the value of a read in the cycle after bus_rd and is 0 after any cycle without a read.
- R11: Entries leave in the order they were pushed, including when the storage pointers wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Datapath push strobe |
| push_data | input | 16 | Word to push |
| bus_addr | input | 2 | Register address: 0 control, 1 data, 2 status |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_be | input | 2 | Byte-lane enables, bit 0 = bits 7:0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| fifo_empty | output | 1 | Store holds no entry |
| fifo_full | output | 1 | Store holds 8 entries |
| fifo_count | output | 4 | Occupancy |
| underflow | output | 1 | Sticky empty-read flag |

## Verification
Some properties are checked on every cycle:
- The count never exceeds the depth.
- A push while full, a high-lane-only read, a disabled-mode cycle and a simultaneous push and removal all leave the count untouched.
- A low-lane read of a non-empty store lowers the count by one.
- An empty test read raises underflow.

Only the bench scenarios can show the data itself. This covers:
- which byte lanes appear on the read bus;
- that a high-then-low pair returns one entry;
- that the order survives a pointer wrap;
- that a push while full leaves no trace in the data that is drained later;
- that the clear-on-write-one rule ignores a written zero.

// File: rtl/ftr_pkg.sv
// Package: shared constants and types for the FIFO test-read port.
// Assumes the register bus addresses at least three registers.
package ftr_pkg;
    localparam int CTRL_W      = 8;
    localparam int TREAD_BIT   = 6;  // test-read enable
    localparam int ANEG_BIT    = 7;  // active-negation enable, stored only
    localparam int CLKHALT_BIT = 5;  // clock halt, stored only
    localparam int ADR_CTRL    = 0;
    localparam int ADR_DATA    = 1;
    localparam int ADR_STAT    = 2;

    typedef enum logic [1:0] {
        ACC_IDLE,   // no data-register test access
        ACC_PEEK,   // lanes read without removal
        ACC_POP,    // lane 0 read, head removed
        ACC_UNDER   // access to an empty store
    } acc_e;
endpackage

// File: rtl/ftr_fifo.sv
// Module: ftr_fifo
// Circular store with occupancy count. It shows the head word combinationally.
// Assumes pop_req is only raised while the store is non-empty. A push while
// full is dropped, and the full test uses the state before any same-cycle pop.
module ftr_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full,
    output logic [CNT_W-1:0]  count
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              push_ok;
    logic              pop_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push_req && !full;
    assign pop_ok  = pop_req && !empty;
    assign head    = mem[rd_ptr];

    // Write the accepted push word into storage.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Advance the pointers and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/ftr_ctrl_regs.sv
// Module: ftr_ctrl_regs
// Holds the 8-bit control register and the sticky underflow flag.
// Assumes only lane 0 carries register bits. If underflow is set and
// cleared in the same cycle, the set wins.
module ftr_ctrl_regs #(
    parameter int ADDR_W = 2,
    parameter int CTRL_W = ftr_pkg::CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              lane0_en,
    input  logic [CTRL_W-1:0] wdata_lo,
    input  logic              uflow_set,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              uflow_q
);
    import ftr_pkg::*;

    logic ctrl_hit;
    logic stat_clr;

    assign ctrl_hit = wr_en && lane0_en && (int'(addr) == ADR_CTRL);
    assign stat_clr = wr_en && lane0_en && (int'(addr) == ADR_STAT) && wdata_lo[0];

    // Capture control writes.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrl_q <= '0;
        else if (ctrl_hit) ctrl_q <= wdata_lo;
    end

    // Set the underflow flag on an empty read, clear it on a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n)         uflow_q <= 1'b0;
        else if (uflow_set) uflow_q <= 1'b1;
        else if (stat_clr)  uflow_q <= 1'b0;
    end
endmodule

// File: rtl/ftr_read_port.sv
// Module: ftr_read_port
// Decodes host reads. It decides whether a data read removes the head,
// masks the read word by byte lane and registers it onto the bus.
// Assumes DATA_W is a multiple of 8 and at least CTRL_W.
module ftr_read_port #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2,
    parameter int CTRL_W = ftr_pkg::CTRL_W,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be,
    input  logic              test_en,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] head,
    input  logic [CTRL_W-1:0] ctrl_q,
    input  logic              uflow_q,
    output logic              pop_req,
    output logic              uflow_set,
    output logic [DATA_W-1:0] rdata
);
    import ftr_pkg::*;

    acc_e              acc;
    logic [DATA_W-1:0] raw_word;
    logic [DATA_W-1:0] lane_word;

    // Classify a data-register read by mode, occupancy and lanes.
    always_comb begin
        acc = ACC_IDLE;
        if (rd_en && test_en && (int'(addr) == ADR_DATA) && (|be)) begin
            if (fifo_empty)  acc = ACC_UNDER;
            else if (be[0])  acc = ACC_POP;
            else             acc = ACC_PEEK;
        end
    end

    assign pop_req   = (acc == ACC_POP);
    assign uflow_set = (acc == ACC_UNDER);

    // Select the unmasked word for the addressed register.
    always_comb begin
        raw_word = '0;
        case (int'(addr))
            ADR_CTRL: raw_word = DATA_W'(ctrl_q);
            ADR_STAT: raw_word = DATA_W'(uflow_q);
            ADR_DATA: raw_word = (acc == ACC_POP || acc == ACC_PEEK) ? head : '0;
            default:  raw_word = '0;
        endcase
    end

    // Zero every byte lane the host did not select.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_word[g*8 +: 8] = be[g] ? raw_word[g*8 +: 8] : 8'h00;
    end

    // Register the read data; idle cycles return zero.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= lane_word;
        else            rdata <= '0;
    end
endmodule

// File: rtl/fifo_tread_port.sv
// Module: fifo_tread_port (top)
// A FIFO of data words with a host register port. When the test-read
// control bit is set, the host can drain the FIFO through the data
// register, and the byte lanes of each read decide whether it removes
// an entry. Assumes a single clock domain and a synchronous active-low reset.
module fifo_tread_port #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 2,
    localparam int LANES = DATA_W / 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [LANES-1:0]  bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic [CNT_W-1:0]  fifo_count,
    output logic              underflow
);
    import ftr_pkg::*;

    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] head;
    logic              test_en;
    logic              pop_req;
    logic              uflow_set;
    logic              unused_wdata_hi;

    assign test_en         = ctrl_q[TREAD_BIT];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CTRL_W];

    ftr_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_valid),
        .push_data (push_data),
        .pop_req   (pop_req),
        .head      (head),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .count     (fifo_count)
    );

    ftr_ctrl_regs #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .lane0_en  (bus_be[0]),
        .wdata_lo  (bus_wdata[CTRL_W-1:0]),
        .uflow_set (uflow_set),
        .ctrl_q    (ctrl_q),
        .uflow_q   (underflow)
    );

    ftr_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_rport (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (bus_rd),
        .addr       (bus_addr),
        .be         (bus_be),
        .test_en    (test_en),
        .fifo_empty (fifo_empty),
        .head       (head),
        .ctrl_q     (ctrl_q),
        .uflow_q    (underflow),
        .pop_req    (pop_req),
        .uflow_set  (uflow_set),
        .rdata      (bus_rdata)
    );
endmodule

// File: rtl/ftr_checks.sv
// Module: ftr_checks
// Cycle-by-cycle properties for fifo_tread_port, attached by bind.
// Assumes the data register sits at ftr_pkg::ADR_DATA.
module ftr_checks #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 2,
    parameter int LANES  = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_valid,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [LANES-1:0]  bus_be,
    input logic              test_en,
    input logic              pop_req,
    input logic              fifo_full,
    input logic              fifo_empty,
    input logic [CNT_W-1:0]  fifo_count,
    input logic              underflow
);
    import ftr_pkg::*;

    logic data_rd;
    assign data_rd = bus_rd && (int'(bus_addr) == ADR_DATA);

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH)); // R3
    AST_FULL_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full && push_valid && !pop_req |=> $stable(fifo_count)); // R3
    AST_WORD_POP: assert property (@(posedge clk) disable iff (!rst_n)
        test_en && !fifo_empty && data_rd && (&bus_be) && !push_valid
        |=> fifo_count == $past(fifo_count) - 1'b1); // R4
    AST_LOW_POP: assert property (@(posedge clk) disable iff (!rst_n)
        test_en && !fifo_empty && data_rd && bus_be[0] && !push_valid
        |=> fifo_count == $past(fifo_count) - 1'b1); // R5
    AST_HIGH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && !bus_be[0] && !push_valid |=> $stable(fifo_count)); // R6
    AST_OFF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en && !push_valid |=> $stable(fifo_count)); // R7
    AST_UFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        test_en && fifo_empty && data_rd && (|bus_be) |=> underflow); // R8
    AST_PAIR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && pop_req && !fifo_full |=> $stable(fifo_count)); // R9
endmodule

bind fifo_tread_port ftr_checks #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .LANES(LANES)
) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .test_en    (test_en),
    .pop_req    (pop_req),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .fifo_count (fifo_count),
    .underflow  (underflow)
);

// File: tb/fifo_tread_port_tb.sv
`timescale 1ns/1ps
// Bench: a table of vectors, then directed tests for reset and corner cases.
module fifo_tread_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [15:0] push_data = '0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        fifo_empty;
    logic        fifo_full;
    logic [3:0]  fifo_count;
    logic        underflow;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fifo_tread_port u_dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .fifo_count(fifo_count), .underflow(underflow)
    );

    // Vector: {req[3:0], op[1:0], addr[1:0], be[1:0], data[15:0], exp_rdata[15:0], exp_count[3:0]}
    // op 0 = push, 1 = bus read, 2 = bus write
    localparam int NV = 14;
    localparam logic [45:0] VECS [NV] = '{
        {4'd2,  2'd2, 2'd0, 2'b01, 16'h0040, 16'h0000, 4'd0},  // R2 enable test read
        {4'd2,  2'd1, 2'd0, 2'b01, 16'h0000, 16'h0040, 4'd0},  // R2 readback
        {4'd3,  2'd0, 2'd0, 2'b00, 16'hA1B2, 16'h0000, 4'd1},  // R3 / R10 idle rdata 0
        {4'd3,  2'd0, 2'd0, 2'b00, 16'hC3D4, 16'h0000, 4'd2},  // R3
        {4'd3,  2'd0, 2'd0, 2'b00, 16'h1357, 16'h0000, 4'd3},  // R3
        {4'd4,  2'd1, 2'd1, 2'b11, 16'h0000, 16'hA1B2, 4'd2},  // R4 word read pops
        {4'd6,  2'd1, 2'd1, 2'b10, 16'h0000, 16'hC300, 4'd2},  // R6 high lane, no pop
        {4'd5,  2'd1, 2'd1, 2'b01, 16'h0000, 16'h00D4, 4'd1},  // R5 low lane pops
        {4'd10, 2'd1, 2'd1, 2'b00, 16'h0000, 16'h0000, 4'd1},  // R10 no lanes
        {4'd2,  2'd2, 2'd0, 2'b01, 16'h00A5, 16'h0000, 4'd1},  // R2 test bit off
        {4'd2,  2'd1, 2'd0, 2'b01, 16'h0000, 16'h00A5, 4'd1},  // R2 readback
        {4'd7,  2'd1, 2'd1, 2'b11, 16'h0000, 16'h0000, 4'd1},  // R7 disabled read
        {4'd2,  2'd2, 2'd0, 2'b01, 16'h0040, 16'h0000, 4'd1},  // R2 re-enable
        {4'd11, 2'd1, 2'd1, 2'b11, 16'h0000, 16'h1357, 4'd0}   // R11 order kept
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus/datapath cycle; results are sampled 1 ns after the edge.
    task automatic cycle(input bit p, input logic [15:0] pd, input bit rd, input bit wr,
                         input logic [1:0] a, input logic [1:0] be, input logic [15:0] wd);
        push_valid = p; push_data = pd; bus_rd = rd; bus_wr = wr;
        bus_addr = a; bus_be = be; bus_wdata = wd;
        @(posedge clk); #1;
        push_valid = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 count", 16'(fifo_count), 16'h0);
        chk("R1 empty", 16'(fifo_empty), 16'h1);
        chk("R1 full", 16'(fifo_full), 16'h0);
        chk("R1 underflow", 16'(underflow), 16'h0);
        cycle(0, 0, 1, 0, 2'd0, 2'b11, 0);
        chk("R1 ctrl", bus_rdata, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            logic [45:0] v;
            string tag;
            v = VECS[i];
            tag = $sformatf("R%0d vec%0d", v[45:42], i);
            cycle(v[41:40] == 2'd0, v[35:20], v[41:40] == 2'd1, v[41:40] == 2'd2,
                  v[39:38], v[37:36], v[35:20]);
            chk({tag, " rdata"}, bus_rdata, v[19:4]);
            chk({tag, " count"}, 16'(fifo_count), 16'(v[3:0]));
        end

        // R3 fill to full across the pointer wrap; R11 drain order
        for (int i = 0; i < 8; i++) cycle(1, 16'h1000 + 16'(i), 0, 0, 0, 0, 0);
        chk("R3 full", 16'(fifo_full), 16'h1);
        chk("R3 count", 16'(fifo_count), 16'd8);
        cycle(1, 16'hDEAD, 0, 0, 0, 0, 0);
        chk("R3 push while full", 16'(fifo_count), 16'd8);
        for (int i = 0; i < 8; i++) begin
            cycle(0, 0, 1, 0, 2'd1, 2'b11, 0);
            chk("R11 drain order", bus_rdata, 16'h1000 + 16'(i));
        end
        chk("R3 drained empty", 16'(fifo_empty), 16'h1);

        // R8 underflow: empty reads, then sticky flag and write-one clear
        cycle(0, 0, 1, 0, 2'd1, 2'b11, 0);
        chk("R8 empty word rdata", bus_rdata, 16'h0000);
        chk("R8 underflow set", 16'(underflow), 16'h1);
        chk("R8 count held", 16'(fifo_count), 16'h0);
        cycle(0, 0, 1, 0, 2'd1, 2'b10, 0);
        chk("R8 empty high rdata", bus_rdata, 16'h0000);
        cycle(0, 0, 1, 0, 2'd2, 2'b01, 0);
        chk("R8 status read", bus_rdata, 16'h0001);
        cycle(0, 0, 0, 1, 2'd2, 2'b01, 16'h0000);
        chk("R8 write zero keeps", 16'(underflow), 16'h1);
        cycle(0, 0, 0, 1, 2'd2, 2'b01, 16'h0001);
        chk("R8 write one clears", 16'(underflow), 16'h0);

        // R9 push and pop in the same cycle
        cycle(1, 16'h0A0A, 0, 0, 0, 0, 0);
        cycle(1, 16'h0B0B, 0, 0, 0, 0, 0);
        cycle(1, 16'h0C0C, 1, 0, 2'd1, 2'b11, 0);
        chk("R9 pair rdata", bus_rdata, 16'h0A0A);
        chk("R9 pair count", 16'(fifo_count), 16'd2);
        cycle(0, 0, 1, 0, 2'd1, 2'b11, 0);
        chk("R9 order 1", bus_rdata, 16'h0B0B);
        cycle(0, 0, 1, 0, 2'd1, 2'b11, 0);
        chk("R9 order 2", bus_rdata, 16'h0C0C);

        // R1 reset mid-run clears state and disables test reads
        cycle(1, 16'h5555, 0, 0, 0, 0, 0);
        cycle(0, 0, 0, 1, 2'd0, 2'b01, 16'h00FF);
        do_reset();
        chk("R1 mid count", 16'(fifo_count), 16'h0);
        chk("R1 mid empty", 16'(fifo_empty), 16'h1);
        cycle(0, 0, 1, 0, 2'd0, 2'b01, 0);
        chk("R1 mid ctrl", bus_rdata, 16'h0000);
        cycle(1, 16'h7777, 0, 0, 0, 0, 0);
        cycle(0, 0, 1, 0, 2'd1, 2'b11, 0);
        chk("R7 after reset rdata", bus_rdata, 16'h0000);
        chk("R7 after reset count", 16'(fifo_count), 16'd1);

        finish_run();
    end
endmodule